// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the programmable 16-bit base address and base count of every channel of a multi-channel DMA controller, together with the live state derived from them: a current address and a progress counter per channel. The processor reaches it through an 8-bit port. One shared byte pointer decides for every access, on any channel and any register, whether the low or the high byte is meant, and the pointer flips after each access. Software therefore writes or reads a 16-bit quantity as two consecutive accesses, low byte first, after it has cleared the pointer with the clear-pointer pulse.

Completing a register with its high byte reloads the channel's current address from the base address and zeroes the progress counter. The transfer side advances the progress counter through a per-channel increment input. Reads do not return the stored registers. An address read gives the current address moved forward or backward by the progress, as the channel's direction input selects. A count read gives the scaled base count less the progress. A word-mode parameter `WSHIFT` scales addresses and counts by a left shift, and it also selects which port offset bits are decoded. There is no data stream here: the interface is a plain register strobe with no back-pressure, and every access completes in the cycle it is presented.

Top module: `dma_chan_regs`

## Requirements
- R1: The port index is `(acc_port >> WSHIFT)` masked to 4 bits. Index bits [3:1] pick the channel and bit 0 picks the register (0 = address, 1 = count). An access to a channel number of NCH or above changes no register and a read from it returns 0x00.
- R2: The byte pointer flips on every cycle with `acc_cs` high, for reads and for writes and whatever the channel. It holds its value on cycles with `acc_cs` low.
- R3: `ptr_clear` forces the pointer to 0 at the next edge and wins over a flip in the same cycle. Pointer 0 selects the low byte and pointer 1 the high byte.
- R4: A write with the pointer at 0 replaces bits [7:0] of the selected base register and keeps bits [15:8].
- R5: A write with the pointer at 1 replaces bits [15:8] of the selected base register. For either register of that channel, it then loads the current address with (base address, new byte included) << WSHIFT and clears the progress counter.
- R6: An address read evaluates the current address plus the progress when `dir_dec[ch]` is 0, and minus the progress when it is 1, modulo 2^(16+WSHIFT).
- R7: A count read evaluates (base count << WSHIFT) minus the progress, modulo 2^(16+WSHIFT).
- R8: A read returns bits [7:0] of the value shifted right by WSHIFT + 8 × pointer, using the pointer before it flips. The byte appears on `rd_byte` after the read's clock edge and holds until the next read.
- R9: Each channel's 17-bit progress counter increments, wrapping, at an edge where `xfer_inc[ch]` is high. A high-byte write to that channel in the same cycle takes priority and leaves it at 0.
- R10: Reset (`rst_n` low) clears the pointer, all base registers, current addresses, progress counters and `rd_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_cs | input | 1 | Access strobe, one access per high cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_port | input | 4+WSHIFT | Port offset within the 16-port window |
| acc_wdata | input | 8 | Write byte |
| ptr_clear | input | 1 | Clear the shared byte pointer |
| dir_dec | input | NCH | Per-channel direction, 1 = address decrements |
| xfer_inc | input | NCH | Per-channel progress increment |
| rd_byte | output | 8 | Byte returned by the last read |

## Verification
A wrong byte pointer shows on the very next read: a read then returns the other half of the value, and each later access in the same pair is off as well. A stale current address or progress counter reaches the port only when software reads that channel. The bench therefore reads back after every kind of update, and it compares `rd_byte` against its own model on every clock, so a fault is caught within one cycle of the read that exposes it. A missed reload or a wrong priority between an increment and a write shows as a count or address byte that is off by the progress.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int PROG_W = 17;

  typedef struct packed {
    logic [2:0] chan;
    logic       is_count;
  } port_sel_t;

  function automatic port_sel_t split_index(input logic [3:0] idx);
    port_sel_t s;
    s.chan     = idx[3:1];
    s.is_count = idx[0];
    return s;
  endfunction
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic clear,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= 1'b0;
    else if (clear)  ptr <= 1'b0;
    else if (access) ptr <= ~ptr;
  end

  AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !clear) |=> (ptr != $past(ptr))); // R2
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !clear) |=> $stable(ptr)); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !ptr); // R3
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot #(
  parameter int WSHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic                 is_count,
  input  logic [7:0]           wdata,
  input  logic                 inc,
  input  logic                 dir,
  output logic [15+WSHIFT:0]   addr_val,
  output logic [15+WSHIFT:0]   cnt_val
);
  import dma_regs_pkg::*;
  localparam int VW = 16 + WSHIFT;

  logic [15:0]       base_a, base_c;
  logic [15:0]       next_base_a;
  logic [VW-1:0]     cur_addr;
  logic [PROG_W-1:0] prog;

  assign next_base_a = is_count ? base_a : {wdata, base_a[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a   <= '0;
      base_c   <= '0;
      cur_addr <= '0;
      prog     <= '0;
    end else begin
      if (wr_lo) begin
        if (is_count) base_c[7:0] <= wdata;
        else          base_a[7:0] <= wdata;
      end
      if (wr_hi) begin
        if (is_count) base_c[15:8] <= wdata;
        else          base_a[15:8] <= wdata;
        cur_addr <= VW'(next_base_a) << WSHIFT;
        prog     <= '0;
      end else if (inc) begin
        prog <= prog + 1'b1;
      end
    end
  end

  always_comb begin
    if (dir) addr_val = cur_addr - VW'(prog);
    else     addr_val = cur_addr + VW'(prog);
    cnt_val = (VW'(base_c) << WSHIFT) - VW'(prog);
  end

  AST_HI_CLEARS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (prog == '0)); // R5
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> ($stable(base_a[15:8]) && $stable(base_c[15:8]))); // R4
  AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_hi) |=> (prog == PROG_W'($past(prog) + 1'b1))); // R9
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH    = 4,
  parameter int WSHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_cs,
  input  logic              acc_wr,
  input  logic [3+WSHIFT:0] acc_port,
  input  logic [7:0]        acc_wdata,
  input  logic              ptr_clear,
  input  logic [NCH-1:0]    dir_dec,
  input  logic [NCH-1:0]    xfer_inc,
  output logic [7:0]        rd_byte
);
  import dma_regs_pkg::*;
  localparam int VW = 16 + WSHIFT;

  logic [3:0]    idx;
  port_sel_t     sel;
  logic          chan_ok;
  logic          ptr;
  logic [VW-1:0] addr_val [NCH];
  logic [VW-1:0] cnt_val  [NCH];
  logic [VW-1:0] pick;
  logic [VW-1:0] pick_sh;
  logic [7:0]    byte_out;

  assign idx     = 4'(acc_port >> WSHIFT);
  assign sel     = split_index(idx);
  assign chan_ok = (32'(sel.chan) < NCH);

  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .access (acc_cs),
    .clear  (ptr_clear),
    .ptr    (ptr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit;
    assign hit = acc_cs && acc_wr && chan_ok && (32'(sel.chan) == c);
    dma_chan_slot #(.WSHIFT(WSHIFT)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (hit && !ptr),
      .wr_hi    (hit && ptr),
      .is_count (sel.is_count),
      .wdata    (acc_wdata),
      .inc      (xfer_inc[c]),
      .dir      (dir_dec[c]),
      .addr_val (addr_val[c]),
      .cnt_val  (cnt_val[c])
    );
  end

  always_comb begin
    pick = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chan_ok && (32'(sel.chan) == c))
        pick = sel.is_count ? cnt_val[c] : addr_val[c];
    end
    pick_sh  = pick >> WSHIFT;
    byte_out = ptr ? pick_sh[15:8] : pick_sh[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 rd_byte <= '0;
    else if (acc_cs && !acc_wr) rd_byte <= byte_out;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_cs && !acc_wr) |=> $stable(rd_byte)); // R8
  AST_BAD_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cs && !acc_wr && !chan_ok) |=> (rd_byte == 8'h00)); // R1
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int NCH = 4;
  localparam int SH  = 1;
  localparam int VMASK = (1 << (16 + SH)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_cs = 1'b0, acc_wr = 1'b0, ptr_clear = 1'b0;
  logic [3+SH:0] acc_port = '0;
  logic [7:0] acc_wdata = '0;
  logic [NCH-1:0] dir_dec = '0, xfer_inc = '0;
  logic [7:0] rd_byte;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R10 reset";

  int ba [NCH], bc [NCH], cur [NCH], prog [NCH];
  int mff, mrd;

  always #4 clk = ~clk;

  dma_chan_regs #(.NCH(NCH), .WSHIFT(SH)) uut (
    .clk(clk), .rst_n(rst_n), .acc_cs(acc_cs), .acc_wr(acc_wr),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .ptr_clear(ptr_clear),
    .dir_dec(dir_dec), .xfer_inc(xfer_inc), .rd_byte(rd_byte));

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    int fo, ix, ch, rg, v;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin ba[c] = 0; bc[c] = 0; cur[c] = 0; prog[c] = 0; end
      mff = 0; mrd = 0;
    end else begin
      fo = mff;
      ix = (int'(acc_port) >> SH) & 15;
      ch = ix >> 1;
      rg = ix & 1;
      if (acc_cs) begin
        if (acc_wr) begin
          if (ch < NCH) begin
            if (fo != 0) begin
              if (rg != 0) bc[ch] = (bc[ch] & 255) | (int'(acc_wdata) << 8);
              else         ba[ch] = (ba[ch] & 255) | (int'(acc_wdata) << 8);
              cur[ch] = (ba[ch] << SH) & VMASK;
              prog[ch] = 0;
            end else begin
              if (rg != 0) bc[ch] = (bc[ch] & 'hFF00) | int'(acc_wdata);
              else         ba[ch] = (ba[ch] & 'hFF00) | int'(acc_wdata);
            end
          end
        end else begin
          if (ch < NCH) begin
            if (rg != 0)         v = (bc[ch] << SH) - prog[ch];
            else if (dir_dec[ch]) v = cur[ch] - prog[ch];
            else                 v = cur[ch] + prog[ch];
            mrd = (v >> (SH + 8 * fo)) & 255;
          end else mrd = 0;
        end
        mff = (fo != 0) ? 0 : 1;
      end
      if (ptr_clear) mff = 0;
      for (int c = 0; c < NCH; c++)
        if (xfer_inc[c] && !(acc_cs && acc_wr && fo != 0 && ch == c))
          prog[c] = (prog[c] + 1) & 'h1FFFF;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (int'(rd_byte) != mrd) begin
      errors++;
      $display("FAIL %s: rd_byte=%02h expected %02h", tag, rd_byte, mrd[7:0]);
    end
  end

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      finish_run();
    end
  end

  task automatic op(input int ix, input bit wr, input int data,
                    input logic [NCH-1:0] inc = '0, input bit clr = 1'b0);
    @(negedge clk);
    acc_cs = 1'b1; acc_wr = wr; acc_port = (4+SH+1)'(ix << SH);
    acc_wdata = 8'(data); xfer_inc = inc; ptr_clear = clr;
  endtask

  task automatic idle(input int n = 1, input logic [NCH-1:0] inc = '0,
                      input bit clr = 1'b0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_cs = 1'b0; acc_wr = 1'b0; xfer_inc = inc; ptr_clear = clr;
    end
  endtask

  initial begin
    tag = "R10 reset";
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(1, '0, 1'b1);
    op(0, 0, 0); op(0, 0, 0); idle(1);

    tag = "R4 R5 address write then read";
    op(2, 1, 'h34); op(2, 1, 'h12); op(2, 0, 0); op(2, 0, 0); idle(1);

    tag = "R7 count write and read";
    op(3, 1, 'h10); op(3, 1, 'h00); op(3, 0, 0); op(3, 0, 0); idle(1);

    tag = "R9 R6 progress forward";
    idle(5, 4'b0010);
    op(2, 0, 0); op(2, 0, 0); op(3, 0, 0); op(3, 0, 0); idle(1);

    tag = "R6 decrement direction";
    dir_dec = 4'b0010;
    op(2, 0, 0); op(2, 0, 0); idle(1);
    dir_dec = 4'b0000;

    tag = "R2 idle keeps pointer";
    op(4, 1, 'h77); idle(4); op(4, 1, 'h55); op(4, 0, 0); op(4, 0, 0); idle(1);

    tag = "R3 clear pointer mid pair";
    op(6, 1, 'hAA); idle(1, '0, 1'b1); op(6, 1, 'hBB); op(6, 1, 'hCC);
    op(6, 0, 0); op(6, 0, 0); idle(1);
    tag = "R3 clear beats flip";
    op(6, 0, 0, '0, 1'b1); op(6, 0, 0); op(6, 0, 0); idle(1);

    tag = "R4 low write keeps high byte";
    op(6, 1, 'h01); op(1, 0, 0, '0, 1'b1);
    op(6, 0, 0); op(6, 0, 0); idle(1);

    tag = "R9 high write beats increment";
    op(7, 1, 'h20); op(7, 1, 'h01, 4'b1000); idle(2, 4'b1000);
    op(7, 0, 0); op(7, 0, 0); op(6, 0, 0); op(6, 0, 0); idle(1);

    tag = "R1 channel above range";
    op(10, 1, 'h99); op(11, 1, 'h88); op(10, 0, 0); op(11, 0, 0);
    op(2, 0, 0); op(2, 0, 0); idle(1);

    tag = "R8 read byte holds";
    op(4, 0, 0); idle(6); op(4, 1, 'h42); idle(3);

    tag = "R1 R6 R7 R8 mixed traffic";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) dir_dec = NCH'($urandom);
      if (r < 7)
        op(int'($urandom_range(0, 15)), r < 3, int'($urandom_range(0, 255)),
           NCH'($urandom), $urandom_range(0, 15) == 0);
      else
        idle(1, NCH'($urandom), $urandom_range(0, 7) == 0);
    end
    idle(3);

    tag = "R10 reset again";
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    op(2, 0, 0); op(2, 0, 0); idle(2);
    finish_run();
  end
endmodule